// File: doc/BRIEF.md
# Logarithmic Two-Way Word Shifter

This block moves a data word left or right by any distance from zero to one less than the word width, in a single combinational pass. Right moves are arithmetic: the vacated upper positions take copies of the word's original top bit, so a signed value is divided by a power of two and rounded toward minus infinity. Left moves are logical: the vacated lower positions take zeros. The width is a power-of-two parameter, 16 by default, and the distance is a plain binary number of log2(width) bits.

Internally the word passes through a chain of stages. Stage i moves the word by 2^i positions when bit i of the distance is set and passes it unchanged otherwise. Every stage moves in the same direction, so the distances add up to the binary value of the distance input. The logic depth grows with log2(width), not with the width.

Words enter and leave on a valid/ready stream. The block holds no storage: the result appears in the same cycle as the operands, `out_valid` follows `in_valid` and `in_ready` follows `out_ready` combinationally. Back-pressure therefore reaches the source at once. While the sink holds `out_ready` low, the source keeps its word, distance and direction stable, and the result stays stable with them. A transfer completes in any cycle in which both valid and ready are high.

Top module: `lbshift`

## Requirements
- R1: With a distance of 0, `out_data` equals `in_data` for either value of `in_left`.
- R2: With `in_left` = 1 and distance k, `out_data` equals `in_data` moved k places toward the top bit, and its low k bits are 0.
- R3: With `in_left` = 0 and distance k, `out_data` equals `in_data` moved k places toward bit 0, and its top k bits equal bit W-1 of `in_data`.
- R4: For every distance from 0 to W-1 the total move equals the binary value of `in_amt`, in both directions.
- R5: With `in_left` = 0 and distance W-1, every bit of `out_data` equals bit W-1 of `in_data`.
- R6: With `in_left` = 1 and distance W-1, bit W-1 of `out_data` equals bit 0 of `in_data` and all other bits are 0.
- R7: `out_valid` equals `in_valid` in the same cycle.
- R8: `in_ready` equals `out_ready` in the same cycle.
- R9: The block keeps no state: the same operands give the same `out_data` whatever came before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Source presents an operand set |
| in_ready | output | 1 | Block can take the operand set (follows `out_ready`) |
| in_data | input | W | Word to be moved |
| in_amt | input | log2(W) | Distance in binary |
| in_left | input | 1 | 1 moves left with zero fill, 0 moves right with sign fill |
| out_valid | output | 1 | Result is present (follows `in_valid`) |
| out_ready | input | 1 | Sink can take the result |
| out_data | output | W | Moved word |

## Verification
Every result of this block, data and both handshake flags, is due in the same cycle as the inputs that produce it, with no clock edge in between. The bench therefore changes inputs on the falling clock edge and samples 1 ns later, so each check sees the settled result of the operands just applied and never one from a neighbouring cycle. Expected words come from bench functions built on the language's own shift operators, applied to every distance in both directions over corner words and seeded random words.

// File: rtl/lbshift_pkg.sv
`timescale 1ns/1ps
package lbshift_pkg;
  // Direction encoding of the in_left pin.
  typedef enum logic {
    MOVE_RIGHT = 1'b0,
    MOVE_LEFT  = 1'b1
  } move_dir_e;
endpackage

// File: rtl/lbshift_stage.sv
`timescale 1ns/1ps
// One power-of-two stage of the cascade.
module lbshift_stage #(
  parameter int W  = 16,
  parameter int SH = 1
) (
  input  logic                     en,
  input  lbshift_pkg::move_dir_e   dir,
  input  logic                     sign,
  input  logic [W-1:0]             d,
  output logic [W-1:0]             q
);
  logic [W-1:0] to_left;
  logic [W-1:0] to_right;

  // Zero enters from the bottom on a left move.
  assign to_left  = {d[W-1-SH:0], {SH{1'b0}}};
  // The original top bit enters from the top on a right move.
  assign to_right = {{SH{sign}}, d[W-1:SH]};

  always_comb begin
    if (!en) begin
      q = d;
    end else if (dir == lbshift_pkg::MOVE_LEFT) begin
      q = to_left;
    end else begin
      q = to_right;
    end
  end
endmodule

// File: rtl/lbshift_flow.sv
`timescale 1ns/1ps
// Stream flags for a block with no storage: both pass straight through.
module lbshift_flow (
  input  logic in_valid,
  input  logic out_ready,
  output logic out_valid,
  output logic in_ready
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/lbshift.sv
`timescale 1ns/1ps
module lbshift #(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic [AW-1:0] in_amt,
  input  logic          in_left,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);
  localparam int NSTAGE = AW;

  lbshift_pkg::move_dir_e dir;
  logic                   sign_bit;
  logic [W-1:0]           tap [NSTAGE+1];

  assign dir      = lbshift_pkg::move_dir_e'(in_left);
  assign sign_bit = in_data[W-1];
  assign tap[0]   = in_data;

  // Stage i moves by 2**i when distance bit i is set.
  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    lbshift_stage #(
      .W  (W),
      .SH (1 << i)
    ) u_stage (
      .en   (in_amt[i]),
      .dir  (dir),
      .sign (sign_bit),
      .d    (tap[i]),
      .q    (tap[i+1])
    );
  end

  assign out_data = tap[NSTAGE];

  lbshift_flow u_flow (
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .in_ready  (in_ready)
  );
endmodule

// File: rtl/lbshift_chk.sv
`timescale 1ns/1ps
module lbshift_chk #(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic [AW-1:0] in_amt,
  input logic          in_left,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data
);
  localparam logic [AW-1:0] AMT_MAX = AW'(W - 1);

  always_comb begin
    if (in_amt == '0) begin
      p_pass_r1: assert (out_data == in_data);
    end
    if (in_left && in_amt != '0) begin
      p_left_zero_r2: assert (out_data[0] == 1'b0);
    end
    if (!in_left) begin
      p_right_sign_r3: assert (out_data[W-1] == in_data[W-1]);
    end
    if (!in_left && in_amt == AMT_MAX) begin
      p_max_right_r5: assert (out_data == {W{in_data[W-1]}});
    end
    if (in_left && in_amt == AMT_MAX) begin
      p_max_left_r6: assert (out_data == {in_data[0], {(W-1){1'b0}}});
    end
    p_valid_r7: assert (out_valid == in_valid);
    p_ready_r8: assert (in_ready == out_ready);
  end
endmodule

bind lbshift lbshift_chk #(.W(W), .AW(AW)) u_chk (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_amt    (in_amt),
  .in_left   (in_left),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_lbshift.sv
`timescale 1ns/1ps
module sim_lbshift;
  localparam int W  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          in_valid, in_ready, in_left, out_valid, out_ready;
  logic [W-1:0]  in_data, out_data;
  logic [AW-1:0] in_amt;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  lbshift #(.W(W), .AW(AW)) u0 (
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .in_amt (in_amt), .in_left (in_left), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data)
  );

  function automatic logic [W-1:0] ref_move(logic [W-1:0] d, int a, logic left);
    if (left) return d << a;
    return W'($signed(d) >>> a);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] d, int a, logic left);
    @(negedge clk);
    in_data = d; in_amt = AW'(a); in_left = left;
    #1;
  endtask

  function automatic string tag_for(int a, logic left);
    if (a == 0) return "R1";
    if (a == W - 1) return left ? "R6" : "R5";
    return left ? "R2" : "R3";
  endfunction

  task automatic sweep(logic [W-1:0] d);
    for (int a = 0; a < W; a++) begin
      for (int l = 0; l < 2; l++) begin
        apply(d, a, l[0]);
        check(tag_for(a, l[0]), out_data, ref_move(d, a, l[0]));
      end
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] first;
    void'($urandom(32'd2718));
    in_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; in_amt = '0; in_left = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 idle", out_data, '0);
    check("R7 idle", {15'd0, out_valid}, 16'd0);
    check("R8 idle", {15'd0, in_ready}, 16'd0);

    // R2 R3 R5 R6 R1 on corner words, every distance both ways (R4)
    sweep(16'h0000); sweep(16'hFFFF); sweep(16'h8000);
    sweep(16'h0001); sweep(16'h7FFF); sweep(16'hA5C3);
    // Seeded random words (R4)
    for (int n = 0; n < 12; n++) sweep(W'($urandom));

    // Specific spot values for R3 and R2
    apply(16'hCB00, 3, 1'b0);
    check("R3 spot", out_data, 16'hF960);
    apply(16'h00CB, 3, 1'b1);
    check("R2 spot", out_data, 16'h0658);

    // R9: same operands after different histories
    apply(16'h1234, 5, 1'b0);
    first = out_data;
    apply(16'hFFFF, 15, 1'b1);
    apply(16'h1234, 5, 1'b0);
    check("R9 history", out_data, first);
    apply(16'h8000, 15, 1'b0);
    apply(16'h1234, 5, 1'b0);
    check("R9 history2", out_data, 16'h0091);

    // R7 R8 handshake flags
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      in_valid = v[0]; out_ready = v[1];
      #1;
      check("R7 valid", {15'd0, out_valid}, {15'd0, v[0]});
      check("R8 ready", {15'd0, in_ready}, {15'd0, v[1]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule